// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Registers

This block holds the software-visible control and status registers that steer a bus-master DMA engine for two storage channels. Every channel has three registers. The command byte carries a run bit and a transfer-direction bit. The status byte carries an active flag, a fault flag, an interrupt flag and general bits, two of which advertise DMA capability for drive 0 and drive 1. The third register is a 32-bit pointer to the descriptor table. Host software reaches the registers through a simple request/response port. The port is decoded only while an I/O-enable input is high.

The block does not fetch descriptors or move data. It tells the DMA engine when to begin and when to give up. When the run bit goes from 0 to 1, the block sends a one-cycle start pulse together with the channel's pointer. When the run bit goes from 1 to 0, it sends a one-cycle abort pulse together with the drive selected on that channel. The engine reports back through a per-channel completion input and a per-channel fault input. An interrupt line stays high while any channel has its interrupt flag set.

Each channel runs a two-state controller. `CH_IDLE` moves to `CH_RUN` on a command write with bit 0 set (transition *launch*, which emits the start pulse). `CH_RUN` moves back to `CH_IDLE` on a command write with bit 0 clear (transition *cancel*, which emits the abort pulse). `CH_RUN` also moves back to `CH_IDLE` on a completion input (transition *finish*, with no pulse). The host access path itself has no state: it answers every request one cycle later.

Top module: `bm_dma_regs`

## Requirements
- R1: After reset, both channels read command 0x00, status 0x60 and pointer 0x00000000, and `irq` is low.
- R2: Channel c occupies byte addresses 8c to 8c+7. The command byte is at +0, the status byte at +2 and the pointer at +4 to +7. The word at +0 reads as {8'h00, status, 8'h00, command}. Read data is right-justified: byte reads return bits [7:0] and halfword reads return bits [15:0]. `req_size` is encoded as 0 = byte, 1 = halfword, 2 = word.
- R3: A write to +0 to +3 of any size other than byte, any write to +4 other than a word, any write to +5 to +7, a read with size 3, and a misaligned halfword or word read all complete with `rsp_err` = 1 and change nothing. A byte write to +1 or +3 is accepted and has no effect.
- R4: A pointer write stores the written value with bits [1:0] forced to 0.
- R5: A command write with bit 0 = 1 while the run bit is clear sets the run bit and status bit 0. One cycle later it raises `start_pulse` for exactly one cycle, with `start_ptr` carrying the channel's pointer.
- R6: A command write with bit 0 = 0 while the run bit is set clears the run bit and status bit 0. It raises `abort_pulse` for one cycle, with `abort_drv` equal to that channel's `drv_sel` bit.
- R7: While the run bit is set, a command write cannot change command bit 3 (direction). While the run bit is clear, bit 3 takes the written value.
- R8: Status bit 0 ignores writes. Writing 1 to bit 1 (fault) or bit 2 (interrupt) clears that bit, and writing 0 leaves it unchanged. Bits 7 to 3 take the written value.
- R9: A completion input on a channel clears its run bit and status bit 0 and sets status bit 2, without an abort pulse. Completion wins over a command or status write in the same cycle.
- R10: A fault input on a channel sets its status bit 1. The fault input wins over a same-cycle clearing write.
- R11: While `io_en` is low, requests still get a response, with `rsp_err` = 0 and `rsp_rdata` = 0, and they change no register and produce no pulse.
- R12: `irq` is high exactly while some channel's status bit 2 is set.
- R13: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Register decode enable |
| req_valid | input | 1 | Host request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address within the register window |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Right-justified read data |
| drv_sel | input | 2 | Selected drive per channel |
| dma_done | input | 2 | Per-channel completion from the DMA engine |
| dma_err | input | 2 | Per-channel fault from the DMA engine |
| start_pulse | output | 2 | One-cycle start request per channel |
| start_ptr | output | 64 | Pointer handed over with start, channel c at [32c+31:32c] |
| abort_pulse | output | 2 | One-cycle abort request per channel |
| abort_drv | output | 2 | Drive addressed by the latest abort, per channel |
| irq | output | 1 | OR of the interrupt flags |

## Verification
The bench changes the direction bit while running. A design without the lock would flip the transfer direction in the middle of a transfer. It writes all ones and then all zeros to the status byte. A design that let software write the active flag, or that treated the interrupt or fault bits as plain storage, would report a wrong status or clear a flag that should stay set. It raises completion in the same cycle as a write that tries to clear the interrupt flag. A design with the wrong priority would lose the completion interrupt. The bench also sends a halfword command write, a byte pointer write and a misaligned read, and it accesses the registers with decode disabled. A design with loose decoding would start a transfer or change the pointer on these accesses.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int DW = 32;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    localparam logic [2:0] OFF_CMD = 3'd0;
    localparam logic [2:0] OFF_STS = 3'd2;
    localparam logic [2:0] OFF_PTR = 3'd4;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int STS_ACT = 0;
    localparam int STS_FLT = 1;
    localparam int STS_INT = 2;

    localparam logic [7:0] STS_RESET = 8'h60;
endpackage

// File: rtl/bm_decode.sv
module bm_decode
    import bm_pkg::*;
#(
    parameter int NCHAN = 2,
    parameter int AW    = 4,
    localparam int CW   = AW - 3
) (
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            io_en,
    input  logic [AW-1:0]   req_addr,
    input  logic [1:0]      req_size,
    output logic [NCHAN-1:0] wr_cmd,
    output logic [NCHAN-1:0] wr_sts,
    output logic [NCHAN-1:0] wr_ptr,
    output logic            acc_err,
    output logic            rd_ok,
    output logic [CW-1:0]   ch_idx
);
    logic [2:0] off;
    logic       live;
    logic       ch_bad;
    logic       w_bad;
    logic       r_bad;
    acc_size_e  sz;

    always_comb begin
        ch_idx = req_addr[AW-1:3];
        off    = req_addr[2:0];
        sz     = acc_size_e'(req_size);
        live   = req_valid && io_en;
        ch_bad = (int'(ch_idx) >= NCHAN);

        // pointer half wants a full aligned word, byte half wants bytes
        if (off[2])
            w_bad = (off[1:0] != 2'b00) || (sz != SZ_WORD);
        else
            w_bad = (sz != SZ_BYTE);
        w_bad = w_bad || ch_bad;

        r_bad = ch_bad || (sz == SZ_BAD)
              || ((sz == SZ_HALF) && off[0])
              || ((sz == SZ_WORD) && (off[1:0] != 2'b00));

        acc_err = live && (req_write ? w_bad : r_bad);
        rd_ok   = live && !req_write && !r_bad;
    end

    for (genvar i = 0; i < NCHAN; i++) begin : g_sel
        logic hit;
        assign hit       = live && req_write && !w_bad && (int'(ch_idx) == i);
        assign wr_cmd[i] = hit && (off == OFF_CMD);
        assign wr_sts[i] = hit && (off == OFF_STS);
        assign wr_ptr[i] = hit && (off == OFF_PTR);
    end
endmodule

// File: rtl/bm_chan.sv
module bm_chan
    import bm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic          wr_sts,
    input  logic          wr_ptr,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    input  logic          fault,
    input  logic          drv_in,
    output logic [7:0]    cmd_q,
    output logic [7:0]    sts_q,
    output logic [DW-1:0] ptr_q,
    output logic          start_p,
    output logic [DW-1:0] start_ptr,
    output logic          abort_p,
    output logic          abort_drv,
    output logic          int_flag
);
    ch_state_e   st, st_nx;
    logic        go_start, go_stop;
    logic        dir_q;
    logic [7:0]  cmd_misc_q;
    logic [4:0]  sts_hi_q;
    logic        int_q, flt_q;
    logic [DW-1:0] ptr_r;

    // next-state logic
    always_comb begin
        st_nx    = st;
        go_start = 1'b0;
        go_stop  = 1'b0;
        unique case (st)
            CH_IDLE: begin
                if (!done && wr_cmd && wdata[CMD_GO]) begin
                    st_nx    = CH_RUN;
                    go_start = 1'b1;
                end
            end
            CH_RUN: begin
                if (done) begin
                    st_nx = CH_IDLE;
                end else if (wr_cmd && !wdata[CMD_GO]) begin
                    st_nx   = CH_IDLE;
                    go_stop = 1'b1;
                end
            end
            default: st_nx = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    // pulses toward the engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_p   <= 1'b0;
            abort_p   <= 1'b0;
            start_ptr <= '0;
            abort_drv <= 1'b0;
        end else begin
            start_p <= go_start;
            abort_p <= go_stop;
            if (go_start) start_ptr <= ptr_r;
            if (go_stop)  abort_drv <= drv_in;
        end
    end

    // register contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= 1'b0;
            cmd_misc_q <= '0;
            sts_hi_q   <= STS_RESET[7:3];
            int_q      <= 1'b0;
            flt_q      <= 1'b0;
            ptr_r      <= '0;
        end else begin
            if (wr_cmd) begin
                cmd_misc_q <= wdata[7:0] & ~((8'd1 << CMD_GO) | (8'd1 << CMD_DIR));
                if (st == CH_IDLE) dir_q <= wdata[CMD_DIR];
            end
            if (wr_sts) sts_hi_q <= wdata[7:3];

            if (done)                          int_q <= 1'b1;
            else if (wr_sts && wdata[STS_INT]) int_q <= 1'b0;

            if (fault)                         flt_q <= 1'b1;
            else if (wr_sts && wdata[STS_FLT]) flt_q <= 1'b0;

            if (wr_ptr) ptr_r <= {wdata[DW-1:2], 2'b00};
        end
    end

    always_comb begin
        cmd_q          = cmd_misc_q;
        cmd_q[CMD_GO]  = (st == CH_RUN);
        cmd_q[CMD_DIR] = dir_q;
        sts_q          = {sts_hi_q, int_q, flt_q, (st == CH_RUN)};
        ptr_q          = ptr_r;
        int_flag       = int_q;
    end

    p_start_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> sts_q[STS_ACT]);
    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !start_p);
    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |-> !cmd_q[CMD_GO]);
    p_dir_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[CMD_GO] && wr_cmd) |=> $stable(cmd_q[CMD_DIR]));
    p_act_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && !done) |=> $stable(sts_q[STS_ACT]));
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sts_q[STS_INT] && !sts_q[STS_ACT] && !cmd_q[CMD_GO] && !abort_p));
    p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> sts_q[STS_FLT]);
    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_p && abort_p));
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
    import bm_pkg::*;
#(
    parameter int NCHAN = 2,
    localparam int CW   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int AW   = CW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [1:0]         req_size,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata,
    input  logic [NCHAN-1:0]   drv_sel,
    input  logic [NCHAN-1:0]   dma_done,
    input  logic [NCHAN-1:0]   dma_err,
    output logic [NCHAN-1:0]   start_pulse,
    output logic [NCHAN*DW-1:0] start_ptr,
    output logic [NCHAN-1:0]   abort_pulse,
    output logic [NCHAN-1:0]   abort_drv,
    output logic               irq
);
    logic [NCHAN-1:0] wr_cmd, wr_sts, wr_ptr, int_v;
    logic             acc_err, rd_ok;
    logic [CW-1:0]    ch_idx;
    logic [7:0]       cmd_a [NCHAN];
    logic [7:0]       sts_a [NCHAN];
    logic [DW-1:0]    ptr_a [NCHAN];
    logic [DW-1:0]    word_sel, shaped;

    bm_decode #(.NCHAN(NCHAN), .AW(AW)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .io_en     (io_en),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .wr_cmd    (wr_cmd),
        .wr_sts    (wr_sts),
        .wr_ptr    (wr_ptr),
        .acc_err   (acc_err),
        .rd_ok     (rd_ok),
        .ch_idx    (ch_idx)
    );

    for (genvar i = 0; i < NCHAN; i++) begin : g_ch
        bm_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cmd    (wr_cmd[i]),
            .wr_sts    (wr_sts[i]),
            .wr_ptr    (wr_ptr[i]),
            .wdata     (req_wdata),
            .done      (dma_done[i]),
            .fault     (dma_err[i]),
            .drv_in    (drv_sel[i]),
            .cmd_q     (cmd_a[i]),
            .sts_q     (sts_a[i]),
            .ptr_q     (ptr_a[i]),
            .start_p   (start_pulse[i]),
            .start_ptr (start_ptr[i*DW +: DW]),
            .abort_p   (abort_pulse[i]),
            .abort_drv (abort_drv[i]),
            .int_flag  (int_v[i])
        );
    end

    always_comb begin
        word_sel = '0;
        for (int i = 0; i < NCHAN; i++) begin
            if (int'(ch_idx) == i)
                word_sel = req_addr[2] ? ptr_a[i] : {8'h00, sts_a[i], 8'h00, cmd_a[i]};
        end
        shaped = word_sel >> {req_addr[1:0], 3'b000};
        unique case (acc_size_e'(req_size))
            SZ_BYTE: shaped = shaped & 32'h0000_00FF;
            SZ_HALF: shaped = shaped & 32'h0000_FFFF;
            default: shaped = shaped;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= rd_ok ? shaped : '0;
        end
    end

    assign irq = |int_v;

    p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_noio_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en) |=> (!rsp_err && rsp_rdata == '0
                                    && start_pulse == '0 && abort_pulse == '0));
    p_irq_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done != '0) |=> irq);
endmodule

// File: tb/tb_bm_dma_regs.sv
module tb_bm_dma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  drv_sel = '0;
    logic [1:0]  dma_done = '0;
    logic [1:0]  dma_err = '0;
    logic [1:0]  start_pulse, abort_pulse, abort_drv;
    logic [63:0] start_ptr;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] got_data;
    logic        got_err, got_valid;
    logic [1:0]  got_start, got_abort;

    always #5 clk = ~clk;

    bm_dma_regs dut (
        .clk(clk), .rst_n(rst_n), .io_en(io_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .drv_sel(drv_sel), .dma_done(dma_done), .dma_err(dma_err),
        .start_pulse(start_pulse), .start_ptr(start_ptr),
        .abort_pulse(abort_pulse), .abort_drv(abort_drv), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; one request cycle, samples at next falling edge
    task automatic acc(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                       input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got_valid = rsp_valid; got_err = rsp_err; got_data = rsp_rdata;
        got_start = start_pulse; got_abort = abort_pulse;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz);
        acc(1'b0, a, sz, 32'h0);
    endtask

    task automatic t_reset;
        chk("R13 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        rd(4'd0, 2'd2);
        chk("R13 rsp_valid", {63'd0, got_valid}, 64'd1);
        chk("R1 R2 ch0 word0", {32'd0, got_data}, 64'h0060_0000);
        rd(4'd8, 2'd2);
        chk("R1 ch1 word0", {32'd0, got_data}, 64'h0060_0000);
        rd(4'd12, 2'd2);
        chk("R1 ch1 ptr", {32'd0, got_data}, 64'd0);
    endtask

    task automatic t_ptr;
        acc(1'b1, 4'd4, 2'd2, 32'h1234_5677);
        rd(4'd4, 2'd2);
        chk("R4 ch0 ptr", {32'd0, got_data}, 64'h1234_5674);
        acc(1'b1, 4'd12, 2'd2, 32'hABCD_EF03);
        rd(4'd12, 2'd2);
        chk("R4 ch1 ptr", {32'd0, got_data}, 64'hABCD_EF00);
        rd(4'd5, 2'd0);
        chk("R2 byte read +5", {32'd0, got_data}, 64'h56);
        rd(4'd6, 2'd1);
        chk("R2 half read +6", {32'd0, got_data}, 64'h1234);
    endtask

    task automatic t_size;
        acc(1'b1, 4'd0, 2'd1, 32'h0001);
        chk("R3 half cmd write err", {63'd0, got_err}, 64'd1);
        chk("R3 no start", {62'd0, got_start}, 64'd0);
        rd(4'd0, 2'd0);
        chk("R3 cmd unchanged", {32'd0, got_data}, 64'd0);
        acc(1'b1, 4'd4, 2'd0, 32'hFF);
        chk("R3 byte ptr write err", {63'd0, got_err}, 64'd1);
        rd(4'd4, 2'd2);
        chk("R3 ptr unchanged", {32'd0, got_data}, 64'h1234_5674);
        rd(4'd2, 2'd2);
        chk("R3 misaligned read err", {63'd0, got_err}, 64'd1);
        acc(1'b1, 4'd1, 2'd0, 32'hFF);
        chk("R3 reserved byte ok", {63'd0, got_err}, 64'd0);
        rd(4'd0, 2'd2);
        chk("R3 reserved no effect", {32'd0, got_data}, 64'h0060_0000);
    endtask

    task automatic t_start;
        acc(1'b1, 4'd0, 2'd0, 32'h09);
        chk("R5 start pulse", {62'd0, got_start}, 64'd1);
        chk("R5 start ptr", {32'd0, start_ptr[31:0]}, 64'h1234_5674);
        rd(4'd2, 2'd0);
        chk("R5 pulse one cycle", {62'd0, got_start}, 64'd0);
        chk("R5 active set", {32'd0, got_data}, 64'h61);
    endtask

    task automatic t_lock;
        acc(1'b1, 4'd0, 2'd0, 32'h01);
        rd(4'd0, 2'd0);
        chk("R7 dir locked", {32'd0, got_data}, 64'h09);
    endtask

    task automatic t_status;
        acc(1'b1, 4'd2, 2'd0, 32'hFF);
        rd(4'd2, 2'd0);
        chk("R8 write ones", {32'd0, got_data}, 64'hF9);
        acc(1'b1, 4'd2, 2'd0, 32'h00);
        rd(4'd2, 2'd0);
        chk("R8 active read-only", {32'd0, got_data}, 64'h01);
    endtask

    task automatic t_stop;
        drv_sel = 2'b01;
        acc(1'b1, 4'd0, 2'd0, 32'h08);
        chk("R6 abort pulse", {62'd0, got_abort}, 64'd1);
        chk("R6 abort drive", {63'd0, abort_drv[0]}, 64'd1);
        rd(4'd2, 2'd0);
        chk("R6 active clear", {32'd0, got_data}, 64'h00);
        rd(4'd0, 2'd0);
        chk("R6 cmd after stop", {32'd0, got_data}, 64'h08);
        acc(1'b1, 4'd0, 2'd0, 32'h00);
        rd(4'd0, 2'd0);
        chk("R7 dir free when idle", {32'd0, got_data}, 64'h00);
    endtask

    task automatic t_done;
        acc(1'b1, 4'd8, 2'd0, 32'h01);
        chk("R5 ch1 start", {62'd0, got_start}, 64'd2);
        chk("R5 ch1 ptr", {32'd0, start_ptr[63:32]}, 64'hABCD_EF00);
        dma_done = 2'b10;
        @(negedge clk);
        dma_done = 2'b00;
        rd(4'd8, 2'd0);
        chk("R9 run cleared", {32'd0, got_data}, 64'h00);
        rd(4'd10, 2'd0);
        chk("R9 status", {32'd0, got_data}, 64'h64);
        chk("R12 irq set", {63'd0, irq}, 64'd1);
        acc(1'b1, 4'd10, 2'd0, 32'h60);
        rd(4'd10, 2'd0);
        chk("R8 zero keeps int", {32'd0, got_data}, 64'h64);
        acc(1'b1, 4'd10, 2'd0, 32'h64);
        rd(4'd10, 2'd0);
        chk("R8 w1c int", {32'd0, got_data}, 64'h60);
        chk("R12 irq clear", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_fault;
        dma_err = 2'b01;
        @(negedge clk);
        dma_err = 2'b00;
        rd(4'd2, 2'd0);
        chk("R10 fault set", {32'd0, got_data}, 64'h02);
        acc(1'b1, 4'd2, 2'd0, 32'h00);
        rd(4'd2, 2'd0);
        chk("R8 fault kept", {32'd0, got_data}, 64'h02);
        acc(1'b1, 4'd2, 2'd0, 32'h02);
        rd(4'd2, 2'd0);
        chk("R8 fault w1c", {32'd0, got_data}, 64'h00);
    endtask

    task automatic t_prec;
        acc(1'b1, 4'd0, 2'd0, 32'h01);
        chk("R5 restart", {62'd0, got_start}, 64'd1);
        dma_done = 2'b01;
        acc(1'b1, 4'd2, 2'd0, 32'h04);
        dma_done = 2'b00;
        chk("R9 no abort on finish", {62'd0, got_abort}, 64'd0);
        rd(4'd2, 2'd0);
        chk("R9 done beats w1c", {32'd0, got_data}, 64'h04);
        rd(4'd0, 2'd0);
        chk("R9 cmd run cleared", {32'd0, got_data}, 64'h00);
        chk("R12 irq", {63'd0, irq}, 64'd1);
        acc(1'b1, 4'd2, 2'd0, 32'h04);
    endtask

    task automatic t_noio;
        io_en = 1'b0;
        acc(1'b1, 4'd4, 2'd2, 32'hFFFF_FFFC);
        chk("R11 valid", {63'd0, got_valid}, 64'd1);
        chk("R11 no err", {63'd0, got_err}, 64'd0);
        acc(1'b1, 4'd0, 2'd0, 32'h01);
        chk("R11 no start", {62'd0, got_start}, 64'd0);
        rd(4'd4, 2'd2);
        chk("R11 read zero", {32'd0, got_data}, 64'd0);
        io_en = 1'b1;
        rd(4'd4, 2'd2);
        chk("R11 ptr kept", {32'd0, got_data}, 64'h1234_5674);
        rd(4'd0, 2'd2);
        chk("R11 cmd kept", {32'd0, got_data}, 64'h0000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ptr;
        t_size;
        t_start;
        t_lock;
        t_status;
        t_stop;
        t_done;
        t_fault;
        t_prec;
        t_noio;
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule